// File: doc/BRIEF.md
# Alarm and Update-End Interrupt Unit

This unit sits beside a real-time clock's calendar counters and handles the end of each once-per-second time update. It counts time-base ticks. When the last tick of a second arrives, it copies the current seconds, minutes and hours into the registers that software reads. The copy is skipped while software holds the freeze control. In the same cycle it compares the three current fields against three alarm fields and records alarm and update-ended events in a status byte. It also drives a level interrupt request.

Each alarm field has its own wildcard code. When both of its top bits are set, the field matches any value. An alarm can therefore fire once a day, once an hour, once a minute or every second. A busy indication rises a fixed number of ticks before the update and falls when the update completes, so software can keep its reads out of that window. Software acknowledges events with a one-cycle clear strobe. That strobe empties the status byte and drops the interrupt.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset the visible time outputs, the status byte, the busy flag and the interrupt output are all zero.
- R2: An update completes on the tick that takes the tick counter from TICKS_PER_SEC-1 back to 0. From the next cycle the visible time outputs equal the current time inputs sampled on that tick, unless set_i was high on it. The visible time outputs change at no other time.
- R3: An alarm field whose bits 7 and 6 are both one matches any current value. A field with only one of those two bits set is compared exactly.
- R4: The alarm is met only when the seconds, minutes and hours fields all match on the same update.
- R5: With aie_i low at the update, no alarm event is recorded, whatever the alarm fields hold.
- R6: An alarm event sets stat_o bit 5 (alarm) and bit 7 (any-interrupt) from the cycle after the update.
- R7: With uie_i high at an update, stat_o bit 4 (update-ended) and bit 7 are set from the next cycle. This happens on every update.
- R8: uip_o rises on the tick that brings the counter to TICKS_PER_SEC-UIP_LEAD, so it is high for the last UIP_LEAD ticks of each second. It falls in the cycle after the update.
- R9: irq_o is high exactly when (stat_o bit 5 and aie_i) or (stat_o bit 4 and uie_i). A stat_clr_i pulse with no update in the same cycle zeroes stat_o from the next cycle.
- R10: When stat_clr_i coincides with an update, the events of that update survive the clear.
- R11: The minutes alarm field is compared with cur_min_i only. A minutes alarm equal to the current hour but not the current minute does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one-cycle pulse |
| set_i | input | 1 | Freeze visible time registers |
| aie_i | input | 1 | Alarm interrupt enable |
| uie_i | input | 1 | Update-ended interrupt enable |
| stat_clr_i | input | 1 | Status read-and-clear strobe |
| cur_sec_i | input | 8 | Current seconds |
| cur_min_i | input | 8 | Current minutes |
| cur_hr_i | input | 8 | Current hours |
| alm_sec_i | input | 8 | Seconds alarm field |
| alm_min_i | input | 8 | Minutes alarm field |
| alm_hr_i | input | 8 | Hours alarm field |
| vis_sec_o | output | 8 | Visible seconds |
| vis_min_o | output | 8 | Visible minutes |
| vis_hr_o | output | 8 | Visible hours |
| uip_o | output | 1 | Update in progress |
| stat_o | output | 8 | Status: bit 7 any, bit 5 alarm, bit 4 update-ended |
| irq_o | output | 1 | Interrupt request |

## Verification
A tick counter that has slipped shows up first on uip_o, whose rising edge lands on the wrong tick. Within one second it also shows up as a visible-time refresh on the wrong cycle. A wrong field comparison or wildcard decode shows up at the very next update as a missing or extra bit 5 in stat_o, together with irq_o. A clear that wins over a new event loses bit 4 in the cycle after the collision. The bench compares every output with a reference model on every cycle, so any such fault is reported within one update period of its cause.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned NUM_FIELDS = 3;  // sec, min, hr
  localparam int unsigned STAT_W     = 8;
  localparam int unsigned ANY_BIT    = 7;
  localparam int unsigned ALM_BIT    = 5;
  localparam int unsigned UPD_BIT    = 4;

  typedef struct packed {
    logic [FIELD_W-1:0] hr;
    logic [FIELD_W-1:0] min;
    logic [FIELD_W-1:0] sec;
  } tod_t;
endpackage

// File: rtl/rtc_upd_timer.sv
module rtc_upd_timer #(
  parameter int unsigned TICKS_PER_SEC = 8,
  parameter int unsigned UIP_LEAD      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic done_o,
  output logic uip_o
);
  localparam int unsigned CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] UIP_AT = CNT_W'(TICKS_PER_SEC - UIP_LEAD);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             uip_q;

  assign cnt_nxt = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  assign done_o  = tick_i && (cnt_q == LAST);
  assign uip_o   = uip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      uip_q <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_nxt;
      if (done_o)                            uip_q <= 1'b0;
      else if (tick_i && cnt_nxt == UIP_AT)  uip_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned FIELD_W    = 8,
  parameter int unsigned NUM_FIELDS = 3
) (
  input  logic [NUM_FIELDS*FIELD_W-1:0] cur_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] alm_i,
  output logic                          match_o
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic [FIELD_W-1:0] a, c;
    logic               wild;
    assign a      = alm_i[f*FIELD_W +: FIELD_W];
    assign c      = cur_i[f*FIELD_W +: FIELD_W];
    assign wild   = &a[FIELD_W-1 -: 2];  // both top bits: don't care
    assign hit[f] = wild || (a == c);
  end

  assign match_o = &hit;
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              alm_evt_i,
  input  logic              upd_evt_i,
  input  logic              aie_i,
  input  logic              uie_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  logic any_q, alm_q, upd_q;

  // set after clear: an event in the clear cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      any_q <= 1'b0;
      alm_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      any_q <= (any_q && !clr_i) || alm_evt_i || upd_evt_i;
      alm_q <= (alm_q && !clr_i) || alm_evt_i;
      upd_q <= (upd_q && !clr_i) || upd_evt_i;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ANY_BIT] = any_q;
    stat_o[ALM_BIT] = alm_q;
    stat_o[UPD_BIT] = upd_q;
  end

  assign irq_o = (alm_q && aie_i) || (upd_q && uie_i);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 8,
  parameter int unsigned UIP_LEAD      = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               set_i,
  input  logic               aie_i,
  input  logic               uie_i,
  input  logic               stat_clr_i,
  input  logic [FIELD_W-1:0] cur_sec_i,
  input  logic [FIELD_W-1:0] cur_min_i,
  input  logic [FIELD_W-1:0] cur_hr_i,
  input  logic [FIELD_W-1:0] alm_sec_i,
  input  logic [FIELD_W-1:0] alm_min_i,
  input  logic [FIELD_W-1:0] alm_hr_i,
  output logic [FIELD_W-1:0] vis_sec_o,
  output logic [FIELD_W-1:0] vis_min_o,
  output logic [FIELD_W-1:0] vis_hr_o,
  output logic               uip_o,
  output logic [STAT_W-1:0]  stat_o,
  output logic               irq_o
);
  tod_t cur_tod, alm_tod, vis_q;
  logic upd_done, alarm_match;

  assign cur_tod = '{hr: cur_hr_i, min: cur_min_i, sec: cur_sec_i};
  assign alm_tod = '{hr: alm_hr_i, min: alm_min_i, sec: alm_sec_i};

  rtc_upd_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .UIP_LEAD      (UIP_LEAD)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .done_o (upd_done),
    .uip_o  (uip_o)
  );

  rtc_alarm_cmp #(
    .FIELD_W    (FIELD_W),
    .NUM_FIELDS (NUM_FIELDS)
  ) u_cmp (
    .cur_i   (cur_tod),
    .alm_i   (alm_tod),
    .match_o (alarm_match)
  );

  rtc_status_reg u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (stat_clr_i),
    .alm_evt_i (upd_done && aie_i && alarm_match),
    .upd_evt_i (upd_done && uie_i),
    .aie_i     (aie_i),
    .uie_i     (uie_i),
    .stat_o    (stat_o),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 vis_q <= '0;
    else if (upd_done && !set_i) vis_q <= cur_tod;
  end

  assign vis_sec_o = vis_q.sec;
  assign vis_min_o = vis_q.min;
  assign vis_hr_o  = vis_q.hr;
endmodule

// File: rtl/rtc_alarm_unit_chk.sv
module rtc_alarm_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       upd_done_i,
  input logic       set_i,
  input logic       aie_i,
  input logic       uie_i,
  input logic       stat_clr_i,
  input logic [7:0] cur_sec_i,
  input logic [7:0] cur_min_i,
  input logic [7:0] cur_hr_i,
  input logic [7:0] vis_sec_o,
  input logic [7:0] vis_min_o,
  input logic [7:0] vis_hr_o,
  input logic       uip_o,
  input logic [7:0] stat_o,
  input logic       irq_o
);
  p_uip_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i |=> !uip_o);

  p_vis_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i && !set_i |=> vis_sec_o == $past(cur_sec_i) &&
                             vis_min_o == $past(cur_min_i) &&
                             vis_hr_o  == $past(cur_hr_i));

  p_vis_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_done_i && !set_i) |=> $stable({vis_sec_o, vis_min_o, vis_hr_o}));

  p_alm_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[5]) |-> $past(aie_i) && $past(upd_done_i));

  p_upd_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i && uie_i |=> stat_o[4] && stat_o[7]);

  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i && !upd_done_i |=> stat_o == 8'h00 && !irq_o);

  p_clr_race_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_i && upd_done_i && uie_i |=> stat_o[4]);
endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_done_i (upd_done),
  .set_i      (set_i),
  .aie_i      (aie_i),
  .uie_i      (uie_i),
  .stat_clr_i (stat_clr_i),
  .cur_sec_i  (cur_sec_i),
  .cur_min_i  (cur_min_i),
  .cur_hr_i   (cur_hr_i),
  .vis_sec_o  (vis_sec_o),
  .vis_min_o  (vis_min_o),
  .vis_hr_o   (vis_hr_o),
  .uip_o      (uip_o),
  .stat_o     (stat_o),
  .irq_o      (irq_o)
);

// File: tb/rtc_alarm_unit_tb.sv
`timescale 1ns/1ps
module rtc_alarm_unit_tb;
  localparam int N    = 8;
  localparam int LEAD = 2;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       tick_i = 0, set_i = 0, aie_i = 0, uie_i = 0, stat_clr_i = 0;
  logic [7:0] cur_sec_i = 0, cur_min_i = 0, cur_hr_i = 0;
  logic [7:0] alm_sec_i = 0, alm_min_i = 0, alm_hr_i = 0;
  logic [7:0] vis_sec_o, vis_min_o, vis_hr_o, stat_o;
  logic       uip_o, irq_o;

  int n_tests = 0, n_fail = 0;
  bit chk_en = 0, finished = 0;

  rtc_alarm_unit #(.TICKS_PER_SEC(N), .UIP_LEAD(LEAD)) u_dut (.*);

  always #5 clk_i = ~clk_i;

  // reference model built from the requirements
  int         m_cnt;
  logic       m_uip, m_any, m_alm, m_upd;
  logic [7:0] m_sec, m_min, m_hr;

  function automatic bit fld_hit(logic [7:0] a, logic [7:0] c);
    return (a[7:6] == 2'b11) || (a == c);
  endfunction

  function automatic bit alarm_hit();
    return fld_hit(alm_sec_i, cur_sec_i) && fld_hit(alm_min_i, cur_min_i) &&
           fld_hit(alm_hr_i, cur_hr_i);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt <= 0; m_uip <= 0; m_any <= 0; m_alm <= 0; m_upd <= 0;
      m_sec <= 0; m_min <= 0; m_hr <= 0;
    end else begin
      automatic bit done = tick_i && (m_cnt == N-1);
      automatic bit ea   = done && aie_i && alarm_hit();
      automatic bit eu   = done && uie_i;
      if (tick_i) m_cnt <= done ? 0 : m_cnt + 1;
      if (done) m_uip <= 0;
      else if (tick_i && (m_cnt + 1 == N - LEAD)) m_uip <= 1;
      m_any <= (m_any && !stat_clr_i) || ea || eu;
      m_alm <= (m_alm && !stat_clr_i) || ea;
      m_upd <= (m_upd && !stat_clr_i) || eu;
      if (done && !set_i) begin m_sec <= cur_sec_i; m_min <= cur_min_i; m_hr <= cur_hr_i; end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (chk_en) begin
    check("R2 visible time", {vis_hr_o, vis_min_o, vis_sec_o}, {m_hr, m_min, m_sec});
    check("R8 busy flag", uip_o, m_uip);
    check("R6 R7 status", stat_o, {m_any, 1'b0, m_alm, m_upd, 4'b0});
    check("R9 irq", irq_o, (m_alm && aie_i) || (m_upd && uie_i));
  end

  task automatic drive_next();
    @(posedge clk_i); #1;
  endtask

  // clear, then exactly N ticks -> exactly one update; check alarm bit
  task automatic one_update(string req, logic [7:0] cs, cm, ch, as, am, ah,
                            logic aie, logic exp_alm);
    stat_clr_i = 1; tick_i = 0; drive_next(); stat_clr_i = 0;
    cur_sec_i = cs; cur_min_i = cm; cur_hr_i = ch;
    alm_sec_i = as; alm_min_i = am; alm_hr_i = ah; aie_i = aie;
    tick_i = 1;
    for (int i = 0; i < N; i++) drive_next();
    tick_i = 0;
    @(negedge clk_i);
    check(req, stat_o[5], exp_alm);
    check(req, irq_o, exp_alm || (stat_o[4] && uie_i));
  endtask

  function automatic logic [7:0] pick_alarm(logic [7:0] c);
    case ($urandom % 4)
      0: return c;
      1: return 8'hC0 | 8'($urandom % 64);
      2: return 8'h80 | c;  // one top bit only: no wildcard
      default: return 8'($urandom % 4);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset vis", {vis_hr_o, vis_min_o, vis_sec_o}, 0);
    check("R1 reset stat", {stat_o, uip_o, irq_o}, 0);
    rst_ni = 1;
    drive_next();
    @(negedge clk_i);
    check("R1 after release", {stat_o, uip_o, irq_o}, 0);
    chk_en = 1;

    // directed corners
    uie_i = 0;
    one_update("R3 all wildcards", 8'h11, 8'h22, 8'h03, 8'hC0, 8'hFF, 8'hC5, 1, 1);
    one_update("R3 one top bit not wild", 8'h11, 8'h22, 8'h03, 8'h80, 8'h22, 8'h03, 1, 0);
    one_update("R4 exact all three", 8'h30, 8'h15, 8'h07, 8'h30, 8'h15, 8'h07, 1, 1);
    one_update("R4 hour mismatch", 8'h30, 8'h15, 8'h07, 8'h30, 8'h15, 8'h08, 1, 0);
    one_update("R5 aie low", 8'h30, 8'h15, 8'h07, 8'h30, 8'h15, 8'h07, 0, 0);
    one_update("R11 min vs hour", 8'h30, 8'h15, 8'h07, 8'h30, 8'h07, 8'h07, 1, 0);
    one_update("R11 min wild", 8'h30, 8'h15, 8'h07, 8'h30, 8'hC7, 8'h07, 1, 1);

    // R10: clear on the update cycle
    uie_i = 1; tick_i = 0;
    while (m_cnt != N-1) begin tick_i = 1; drive_next(); tick_i = 0; drive_next(); end
    tick_i = 1; stat_clr_i = 1; drive_next(); tick_i = 0; stat_clr_i = 0;
    @(negedge clk_i);
    check("R10 clear vs update", stat_o[4], 1'b1);

    // R7: every update, with uie held
    for (int k = 0; k < 3; k++) begin
      stat_clr_i = 1; drive_next(); stat_clr_i = 0;
      tick_i = 1; for (int i = 0; i < N; i++) drive_next(); tick_i = 0;
      @(negedge clk_i);
      check("R7 update flag", {stat_o[7], stat_o[4]}, 2'b11);
    end

    // constrained random
    for (int c = 0; c < 3000; c++) begin
      tick_i     = ($urandom % 4) != 0;
      set_i      = ($urandom % 5) == 0;
      aie_i      = ($urandom % 4) != 0;
      uie_i      = ($urandom % 3) != 0;
      stat_clr_i = ($urandom % 10) == 0;
      cur_sec_i  = 8'($urandom % 4);
      cur_min_i  = 8'($urandom % 4);
      cur_hr_i   = 8'($urandom % 4);
      alm_sec_i  = pick_alarm(cur_sec_i);
      alm_min_i  = pick_alarm(cur_min_i);
      alm_hr_i   = pick_alarm(cur_hr_i);
      drive_next();
    end
    @(negedge clk_i);
    chk_en = 0;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule